// File: doc/BRIEF.md
# Multi-Queue Pipelined Read Port

This block is the read side of a FIFO that keeps 32 logical queues and delivers their words through one shared output register. An 8-bit read address picks the queue. The lower five bits give the queue number and the upper three bits must match a static device identifier, so that several such blocks can share one address bus. Each queue storage presents its head word and an empty flag. The block pulls words by raising a one-hot pop request for the queue it is reading.

Switching queues costs no bus cycles. On the edge that accepts a new address, a word can still be taken from the old queue. On the next edge one more word of the old queue falls through on its own. From the second edge after the selection, words come from the new queue. If that queue is empty, the last word stays in the output register and the valid flag drops.

The output side is a plain strobe interface. `ren_n` low is the consumer's ready. `ov_n` low marks the register content as a valid word. While `ren_n` is high the register holds, which is the back-pressure. The one exception is the forced fall-through edge that follows a selection.

Top module: `mq_read_port`

## Requirements
- R1: After reset `ov_n` is 1, `prot_err` is 0, the output register holds 0, queue 0 is the read source and no pop request is raised.
- R2: `rd_addr` is sampled only on a rising edge where `addr_en` is 1. The queue it picks stays the source until another selection is accepted.
- R3: `rd_addr[7:5]` selects the device and `rd_addr[4:0]` selects the queue. When bits 7:5 differ from `dev_id`, the selection is ignored and raises no error.
- R4: On an edge with `ren_n` low and a non-empty source queue, the head word of the source is loaded into the output register and `ov_n` becomes 0. With `ren_n` high and no forced edge, the register and `ov_n` hold.
- R5: On a read edge where the source queue is empty, the register keeps its word and `ov_n` becomes 1.
- R6: On the edge that accepts a selection, the read, if any, still comes from the previous queue and follows the R4 rule.
- R7: On the edge after an accepted selection, one word is read from the previous queue whatever `ren_n` is. If that queue is empty, the R5 rule applies.
- R8: From the second edge after an accepted selection, reads come from the newly selected queue.
- R9: When the newly selected queue is empty, the last word of the old queue remains in the register and `ov_n` becomes 1.
- R10: `oe_n` high puts `q_out` in high impedance only. Words keep loading into the output register and appear once `oe_n` is low again.
- R11: A selection for this device on the edge right after an accepted one is ignored and sets `prot_err`. `prot_err` stays set until reset. A selection two edges after the accepted one is accepted.
- R12: `rd_req` is one-hot or zero. Its bit for the source queue is 1 exactly when that edge reads (`ren_n` low or a forced edge) and the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 8 | Device ID [7:5] and queue number [4:0] |
| addr_en | input | 1 | Address sample strobe |
| ren_n | input | 1 | Read enable, active low (consumer ready) |
| oe_n | input | 1 | Output enable, active low |
| dev_id | input | 3 | Static device identifier |
| q_empty | input | 32 | Per-queue empty flags from storage |
| q_head | input | 576 | Head word of each queue, queue i at bits [i*18 +: 18] |
| rd_req | output | 32 | Per-queue pop request, taken on the rising edge |
| q_out | output | 18 | Output register, high impedance while `oe_n` is high |
| ov_n | output | 1 | Output valid, active low |
| prot_err | output | 1 | Sticky flag for a selection that came too soon |

## Verification
The assertions assume that the storage pops a queue exactly on the edges where its `rd_req` bit is high. They also assume that `q_empty` and `q_head` change only as a result of those pops or of writes between edges. The bench's storage wrapper keeps one behavioural queue per queue number. It drives the empty flags and head words from those queues before each rising edge and pops only the queue the reference model reads. Stimulus changes only on falling edges. Selections are spaced at least two edges apart, except in the one scenario that checks the error flag.

// File: rtl/mq_read_pkg.sv
package mq_read_pkg;
  localparam int unsigned DEF_DATA_W = 18;
  localparam int unsigned DEF_NUM_Q  = 32;
  localparam int unsigned DEF_ID_W   = 3;

  // Selection pipeline phase: idle, or the forced fall-through edge pending
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SWAP = 1'b1
  } sel_phase_e;
endpackage

// File: rtl/mq_sel_ctrl.sv
module mq_sel_ctrl
  import mq_read_pkg::*;
#(
  parameter int unsigned NUM_Q = DEF_NUM_Q,
  parameter int unsigned ID_W  = DEF_ID_W,
  localparam int unsigned QS_W = $clog2(NUM_Q),
  localparam int unsigned AW   = ID_W + QS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr,
  input  logic            addr_en,
  input  logic [ID_W-1:0] dev_id,
  output logic [QS_W-1:0] src_q,
  output logic            forced,
  output logic            accept,
  output logic            prot_err
);
  sel_phase_e      phase_q;
  logic [QS_W-1:0] pend_q;
  logic            id_hit, req;

  assign id_hit = (rd_addr[AW-1 -: ID_W] == dev_id);
  assign req    = addr_en && id_hit;
  assign accept = req && (phase_q == PH_IDLE);
  assign forced = (phase_q == PH_SWAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      pend_q   <= '0;
      src_q    <= '0;
      prot_err <= 1'b0;
    end else begin
      if (phase_q == PH_SWAP) begin
        src_q   <= pend_q;
        phase_q <= PH_IDLE;
        if (req) prot_err <= 1'b1;
      end else if (accept) begin
        pend_q  <= rd_addr[QS_W-1:0];
        phase_q <= PH_SWAP;
      end
    end
  end

  a_r11_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> prot_err);
  a_r2_src_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |=> $stable(src_q));
endmodule

// File: rtl/mq_head_mux.sv
module mq_head_mux
  import mq_read_pkg::*;
#(
  parameter int unsigned NUM_Q  = DEF_NUM_Q,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned QS_W  = $clog2(NUM_Q)
) (
  input  logic [QS_W-1:0]         src_q,
  input  logic                    rd_go,
  input  logic [NUM_Q-1:0]        q_empty,
  input  logic [NUM_Q*DATA_W-1:0] q_head,
  output logic [NUM_Q-1:0]        rd_req,
  output logic [DATA_W-1:0]       word,
  output logic                    word_ok
);
  for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_req
    assign rd_req[gi] = rd_go && (src_q == QS_W'(gi)) && !q_empty[gi];
  end

  always_comb begin
    word    = '0;
    word_ok = 1'b0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (src_q == QS_W'(i)) begin
        word    = q_head[i*DATA_W +: DATA_W];
        word_ok = !q_empty[i];
      end
    end
  end

  always_comb begin
    a_r12_onehot: assert ($onehot0(rd_req));
    a_r12_no_empty_pop: assert ((rd_req & q_empty) == '0);
  end
endmodule

// File: rtl/mq_out_reg.sv
module mq_out_reg
  import mq_read_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              word_ok,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] data_q,
  output logic              ov_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ov_n   <= 1'b1;
    end else if (load) begin
      if (word_ok) begin
        data_q <= word;
        ov_n   <= 1'b0;
      end else begin
        ov_n   <= 1'b1;
      end
    end
  end

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(data_q) && $stable(ov_n)));
  a_r5_keep_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !word_ok) |=> ($stable(data_q) && ov_n));
  a_r4_valid_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word_ok) |=> !ov_n);
endmodule

// File: rtl/mq_read_port.sv
module mq_read_port
  import mq_read_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NUM_Q  = DEF_NUM_Q,
  parameter int unsigned ID_W   = DEF_ID_W,
  localparam int unsigned QS_W  = $clog2(NUM_Q),
  localparam int unsigned AW    = ID_W + QS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           rd_addr,
  input  logic                    addr_en,
  input  logic                    ren_n,
  input  logic                    oe_n,
  input  logic [ID_W-1:0]         dev_id,
  input  logic [NUM_Q-1:0]        q_empty,
  input  logic [NUM_Q*DATA_W-1:0] q_head,
  output logic [NUM_Q-1:0]        rd_req,
  output logic [DATA_W-1:0]       q_out,
  output logic                    ov_n,
  output logic                    prot_err
);
  logic [QS_W-1:0]   src_q;
  logic              forced, accept, rd_go, word_ok;
  logic [DATA_W-1:0] word, data_q;

  mq_sel_ctrl #(.NUM_Q(NUM_Q), .ID_W(ID_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_en(addr_en),
    .dev_id(dev_id), .src_q(src_q), .forced(forced), .accept(accept),
    .prot_err(prot_err)
  );

  assign rd_go = !ren_n || forced;

  mq_head_mux #(.NUM_Q(NUM_Q), .DATA_W(DATA_W)) u_mux (
    .src_q(src_q), .rd_go(rd_go), .q_empty(q_empty), .q_head(q_head),
    .rd_req(rd_req), .word(word), .word_ok(word_ok)
  );

  mq_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(rd_go), .word_ok(word_ok),
    .word(word), .data_q(data_q), .ov_n(ov_n)
  );

  assign q_out = oe_n ? {DATA_W{1'bz}} : data_q;

  a_r7_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_go);
endmodule

// File: tb/mq_read_port_tb.sv
`timescale 1ns/1ps
module mq_read_port_tb_top;
  localparam int W  = 18;
  localparam int NQ = 32;
  localparam logic [2:0] DEV = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rd_addr = '0;
  logic addr_en = 1'b0, ren_n = 1'b1, oe_n = 1'b0;
  logic [NQ-1:0] q_empty;
  logic [NQ*W-1:0] q_head;
  logic [NQ-1:0] rd_req;
  logic [W-1:0] q_out;
  logic ov_n, prot_err;

  always #4 clk = ~clk;

  mq_read_port dut_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_en(addr_en),
    .ren_n(ren_n), .oe_n(oe_n), .dev_id(DEV), .q_empty(q_empty),
    .q_head(q_head), .rd_req(rd_req), .q_out(q_out), .ov_n(ov_n),
    .prot_err(prot_err)
  );

  logic [W-1:0] store [NQ][$];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_src = 0, m_pend = 0;
  bit m_swap = 0, m_err = 0, m_ov_n = 1;
  logic [W-1:0] m_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic refresh();
    for (int i = 0; i < NQ; i++) begin
      q_empty[i] = (store[i].size() == 0);
      q_head[i*W +: W] = (store[i].size() != 0) ? store[i][0] : '0;
    end
  endtask

  task automatic fill(input int q, input int n, input int base);
    for (int k = 0; k < n; k++) store[q].push_back(W'(base + k));
  endtask

  task automatic step(input bit aen, input logic [7:0] addr, input bit ren,
                      input bit oe, input string tag);
    bit go, ne, req;
    logic [NQ-1:0] exp_req;
    @(negedge clk);
    addr_en = aen; rd_addr = addr; ren_n = ren; oe_n = oe;
    refresh();
    #1;
    req = aen && (addr[7:5] == DEV);
    go  = !ren || m_swap;
    ne  = store[m_src].size() != 0;
    exp_req = (go && ne) ? (NQ'(1) << m_src) : '0;
    chk(rd_req == exp_req, tag, "R12 rd_req", 64'(rd_req), 64'(exp_req));
    if (go) begin
      if (ne) begin m_data = store[m_src].pop_front(); m_ov_n = 0; end
      else m_ov_n = 1;
    end
    if (m_swap) begin
      m_src = m_pend; m_swap = 0;
      if (req) m_err = 1;
    end else if (req) begin
      m_pend = int'(addr[4:0]); m_swap = 1;
    end
    @(posedge clk);
    #1;
    chk(ov_n == m_ov_n, tag, "ov_n", 64'(ov_n), 64'(m_ov_n));
    chk(prot_err == m_err, tag, "R11 prot_err", 64'(prot_err), 64'(m_err));
    if (!oe) chk(q_out == m_data, tag, "q_out", 64'(q_out), 64'(m_data));
  endtask

  function automatic logic [7:0] sel(input logic [2:0] id, input int q);
    return {id, 5'(q)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    refresh();
    repeat (3) @(posedge clk);
    #1;
    chk(ov_n == 1'b1, "R1", "ov_n", 64'(ov_n), 64'd1);
    chk(prot_err == 1'b0, "R1", "prot_err", 64'(prot_err), 64'd0);
    chk(q_out == '0, "R1", "q_out", 64'(q_out), 64'd0);
    chk(rd_req == '0, "R1", "rd_req", 64'(rd_req), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    fill(0, 14, 'h100); fill(5, 6, 'h500); fill(31, 4, 'h3f00);
    fill(7, 3, 'h700);
    // R4: reads and back-pressure hold
    step(0, 0, 0, 0, "R4 read");
    step(0, 0, 0, 0, "R4 read");
    step(0, 0, 1, 0, "R4 hold");
    step(0, 0, 1, 0, "R4 hold");
    step(0, 0, 0, 0, "R4 read");
    // R2: address without strobe is not sampled
    step(0, sel(DEV, 5), 0, 0, "R2 no strobe");
    step(0, sel(DEV, 5), 0, 0, "R2 no strobe");
    // R3: foreign device ID ignored
    step(1, sel(3'b010, 5), 0, 0, "R3 foreign id");
    step(0, 0, 0, 0, "R3 foreign id");
    step(0, 0, 0, 0, "R3 foreign id");
    // R6/R7/R8: switch to queue 5, forced edge with ren_n high
    step(1, sel(DEV, 5), 0, 0, "R6 select edge");
    step(0, 0, 1, 0, "R7 forced read");
    step(0, 0, 0, 0, "R8 new queue");
    step(0, 0, 0, 0, "R8 new queue");
    step(0, 0, 1, 0, "R8 hold");
    // R6 with ren_n high on the selecting edge
    step(1, sel(DEV, 7), 1, 0, "R6 select no read");
    step(0, 0, 1, 0, "R7 forced read");
    step(0, 0, 0, 0, "R8 new queue");
    // R5: drain queue 7 and read on empty
    step(0, 0, 0, 0, "R5 drain");
    step(0, 0, 0, 0, "R5 drain");
    step(0, 0, 0, 0, "R5 empty read");
    step(0, 0, 1, 0, "R5 empty hold");
    // R7 forced edge on empty old queue, then queue 31
    step(1, sel(DEV, 31), 1, 0, "R7 forced empty");
    step(0, 0, 1, 0, "R7 forced empty");
    step(0, 0, 0, 0, "R8 new queue");
    // R11: too-early selection ignored, then spacing of two accepted
    step(1, sel(DEV, 5), 0, 0, "R11 first select");
    step(1, sel(DEV, 0), 0, 0, "R11 early select");
    step(0, 0, 0, 0, "R11 source kept");
    step(1, sel(DEV, 9), 0, 0, "R11 spaced select");
    step(0, 0, 0, 0, "R9 forced old");
    // R9: queue 9 empty, old word held with ov_n high
    step(0, 0, 0, 0, "R9 empty new queue");
    step(0, 0, 0, 0, "R9 empty new queue");
    // R10: output disabled while loading continues
    step(1, sel(DEV, 0), 0, 1, "R10 select");
    step(0, 0, 0, 1, "R10 loading");
    step(0, 0, 0, 1, "R10 loading");
    step(0, 0, 1, 0, "R10 enabled again");
    step(0, 0, 0, 0, "R10 read");
    // R2: late push to queue 0 while selected
    fill(0, 2, 'h1ab);
    step(0, 0, 0, 0, "R2 selection persists");
    step(0, 0, 0, 0, "R2 selection persists");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule